// File: doc/BRIEF.md
# Time-Multiplexed Lookup Table with Host Update Port

This block keeps one single-port memory array inside itself and presents two independent ports on top of it. The lookup port is meant for a datapath that needs a table result with fixed, predictable timing. The host port reads and rewrites table contents while lookups keep running. Ownership of the array alternates every clock cycle between a lookup slot and a host slot. The lookup result sits in an output register that is held steady while the host owns the array.

The array also needs periodic maintenance cycles, in the manner of a dynamic memory. An interval timer raises maintenance requests. The requests queue up to a small limit and are served one per host slot, ahead of any host request. Because maintenance never enters the lookup slot, it can slow the host but never a lookup.

The slot state machine has two states. `SLOT_LOOKUP` always moves to `SLOT_HOST`, and `SLOT_HOST` always moves to `SLOT_LOOKUP`. Reset leaves the machine in `SLOT_LOOKUP`. In each cycle the machine decodes one action. `ACT_LOOKUP` is taken in every lookup slot. In a host slot it takes `ACT_REFRESH` when maintenance is pending, otherwise `ACT_HOST_WR` or `ACT_HOST_RD` when the host presents a request, and otherwise `ACT_IDLE`.

Top module: `tdm_lut`

## Requirements
- R1: The array owner alternates every cycle between the lookup slot and the host slot, starting in the lookup slot after reset; `host_ready` is never high in a lookup slot.
- R2: `lut_addr` is sampled on the clock edge that starts a lookup slot, and `lut_data` shows the word stored at that address after the second clock edge following the sampling edge.
- R3: `lut_data` changes only on the edge that ends a host slot and holds through every lookup slot; its latency stays the same under continuous host writes.
- R4: A host write accepted in a host slot is returned by a lookup of the same address sampled on the edge that ends that slot; the value already shown in `lut_data` is kept until that lookup updates it.
- R5: A host request is accepted on a clock edge where `host_valid` and `host_ready` are both high (`host_write` = 1 writes, 0 reads). For an accepted read, `host_rvalid` is high during the following cycle and `host_rdata` holds the addressed word.
- R6: When `refresh_interval` is N > 0, one maintenance request is raised every N cycles; when it is 0, no requests are raised.
- R7: While any maintenance request is pending, `host_ready` stays low, and each host slot serves exactly one pending request; a host request held on the port waits and is carried out afterwards.
- R8: The number of pending maintenance requests saturates at 4, so after requests stop, exactly 4 host slots are blocked.
- R9: After reset, `lut_data` is zero, `host_rvalid` is low and the first cycle is a lookup slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lut_addr | input | ADDR_W | Lookup address, sampled at the start of each lookup slot |
| lut_data | output | DATA_W | Held lookup result |
| host_valid | input | 1 | Host request present |
| host_ready | output | 1 | Host request can be accepted this cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | Host read data valid |
| refresh_interval | input | RF_CNT_W | Cycles between maintenance requests; 0 disables them |

## Verification
The bench builds the block with the default 256-word by 8-bit array, so the lowest and highest addresses (0x00 and 0xFF) can both be used as table entries. It sets the interval timer to 8 bits and keeps the pending limit at 4. With an interval of 1, requests arrive faster than host slots can serve them, which drives the queue into saturation. An interval of 10 gives a known count of blocked host slots over a fixed window.

// File: rtl/tdm_lut_pkg.sv
package tdm_lut_pkg;

    typedef enum logic {
        SLOT_LOOKUP = 1'b0,
        SLOT_HOST   = 1'b1
    } slot_e;

    typedef enum logic [2:0] {
        ACT_LOOKUP  = 3'd0,
        ACT_HOST_RD = 3'd1,
        ACT_HOST_WR = 3'd2,
        ACT_REFRESH = 3'd3,
        ACT_IDLE    = 3'd4
    } act_e;

endpackage

// File: rtl/lut_sp_array.sv
module lut_sp_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // storage: one access per cycle, write or read
    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[addr] <= wdata;
        end
    end

    // registered read port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (en && !we) begin
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/lut_refresh_sched.sv
module lut_refresh_sched #(
    parameter int CNT_W    = 16,
    parameter int PEND_MAX = 4,
    parameter int ROW_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] interval,
    input  logic             serve,
    output logic             pending,
    output logic [ROW_W-1:0] row
);
    localparam int PEND_W = $clog2(PEND_MAX + 1);
    localparam logic [PEND_W:0] PMAX = (PEND_W+1)'(PEND_MAX);

    logic [CNT_W-1:0]  tmr_q;
    logic              tick;
    logic [PEND_W-1:0] pend_q;
    logic [PEND_W:0]   pend_sum;
    logic [ROW_W-1:0]  row_q;

    always_comb begin
        tick = (interval != '0) && (tmr_q >= interval - CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (interval == '0 || tick) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_q + CNT_W'(1);
        end
    end

    always_comb begin
        pend_sum = {1'b0, pend_q} + (PEND_W+1)'(tick) - (PEND_W+1)'(serve);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            row_q  <= '0;
        end else begin
            pend_q <= (pend_sum > PMAX) ? PMAX[PEND_W-1:0] : pend_sum[PEND_W-1:0];
            if (serve) begin
                row_q <= row_q + ROW_W'(1);
            end
        end
    end

    assign pending = (pend_q != '0);
    assign row     = row_q;

    assert_pending_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, pend_q} <= PMAX);

    assert_serve_needs_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        serve |-> pend_q != '0);

    assert_tick_queues_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !serve && ({1'b0, pend_q} < PMAX)) |=> pend_q == $past(pend_q) + PEND_W'(1));

endmodule

// File: rtl/lut_slot_arbiter.sv
module lut_slot_arbiter
    import tdm_lut_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [ADDR_W-1:0] lkp_addr,
    input  logic              rf_pending,
    input  logic [ADDR_W-1:0] rf_row,
    output slot_e             slot,
    output logic              host_ready,
    output logic              arr_en,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              rf_serve,
    output logic              host_rd_go
);
    slot_e slot_q, slot_d;
    act_e  act;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= SLOT_LOOKUP;
        end else begin
            slot_q <= slot_d;
        end
    end

    // transitions and action decode
    always_comb begin
        slot_d = SLOT_LOOKUP;
        act    = ACT_IDLE;
        unique case (slot_q)
            SLOT_LOOKUP: begin
                slot_d = SLOT_HOST;
                act    = ACT_LOOKUP;
            end
            SLOT_HOST: begin
                slot_d = SLOT_LOOKUP;
                if (rf_pending) begin
                    act = ACT_REFRESH;
                end else if (host_valid) begin
                    act = host_write ? ACT_HOST_WR : ACT_HOST_RD;
                end else begin
                    act = ACT_IDLE;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        arr_en     = 1'b0;
        arr_we     = 1'b0;
        arr_addr   = '0;
        rf_serve   = 1'b0;
        host_rd_go = 1'b0;
        unique case (act)
            ACT_LOOKUP: begin
                arr_en   = 1'b1;
                arr_addr = lkp_addr;
            end
            ACT_HOST_RD: begin
                arr_en     = 1'b1;
                arr_addr   = host_addr;
                host_rd_go = 1'b1;
            end
            ACT_HOST_WR: begin
                arr_en   = 1'b1;
                arr_we   = 1'b1;
                arr_addr = host_addr;
            end
            ACT_REFRESH: begin
                arr_en   = 1'b1;
                arr_addr = rf_row;
                rf_serve = 1'b1;
            end
            ACT_IDLE: begin
                arr_en = 1'b0;
            end
            default: begin
                arr_en = 1'b0;
            end
        endcase
    end

    assign slot       = slot_q;
    assign host_ready = (slot_q == SLOT_HOST) && !rf_pending;

    assert_lookup_then_host_R1: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q == SLOT_LOOKUP |=> slot_q == SLOT_HOST);

    assert_host_then_lookup_R1: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q == SLOT_HOST |=> slot_q == SLOT_LOOKUP);

    assert_lookup_slot_owns_array_R3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q == SLOT_LOOKUP |-> (arr_en && !arr_we && arr_addr == lkp_addr));

endmodule

// File: rtl/tdm_lut.sv
module tdm_lut
    import tdm_lut_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int RF_CNT_W = 16,
    parameter int RF_MAX   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   lut_addr,
    output logic [DATA_W-1:0]   lut_data,
    input  logic                host_valid,
    output logic                host_ready,
    input  logic                host_write,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic [DATA_W-1:0]   host_rdata,
    output logic                host_rvalid,
    input  logic [RF_CNT_W-1:0] refresh_interval
);
    slot_e             slot;
    logic [ADDR_W-1:0] lkp_addr_q;
    logic [DATA_W-1:0] lut_q;
    logic              rvalid_q;
    logic              rf_pending;
    logic              rf_serve;
    logic [ADDR_W-1:0] rf_row;
    logic              arr_en;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_addr;
    logic [DATA_W-1:0] arr_rdata;
    logic              host_rd_go;

    lut_slot_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_valid (host_valid),
        .host_write (host_write),
        .host_addr  (host_addr),
        .lkp_addr   (lkp_addr_q),
        .rf_pending (rf_pending),
        .rf_row     (rf_row),
        .slot       (slot),
        .host_ready (host_ready),
        .arr_en     (arr_en),
        .arr_we     (arr_we),
        .arr_addr   (arr_addr),
        .rf_serve   (rf_serve),
        .host_rd_go (host_rd_go)
    );

    lut_refresh_sched #(
        .CNT_W    (RF_CNT_W),
        .PEND_MAX (RF_MAX),
        .ROW_W    (ADDR_W)
    ) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .interval (refresh_interval),
        .serve    (rf_serve),
        .pending  (rf_pending),
        .row      (rf_row)
    );

    lut_sp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (arr_en),
        .we    (arr_we),
        .addr  (arr_addr),
        .wdata (host_wdata),
        .rdata (arr_rdata)
    );

    // the edge ending a host slot samples the next lookup address and
    // moves the previous lookup word into the held output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lkp_addr_q <= '0;
            lut_q      <= '0;
            rvalid_q   <= 1'b0;
        end else begin
            rvalid_q <= host_rd_go;
            if (slot == SLOT_HOST) begin
                lkp_addr_q <= lut_addr;
                lut_q      <= arr_rdata;
            end
        end
    end

    assign lut_data    = lut_q;
    assign host_rdata  = arr_rdata;
    assign host_rvalid = rvalid_q;

    assert_hold_in_lookup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        slot == SLOT_LOOKUP |=> $stable(lut_data));

    assert_refresh_blocks_host_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_pending |-> !host_ready);

    assert_refresh_in_host_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_serve |-> slot == SLOT_HOST);

    assert_rvalid_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_ready && !host_write) |=> host_rvalid);

endmodule

// File: tb/tdm_lut_test.sv
`timescale 1ns/1ps
module tdm_lut_test;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int CW = 8;
    localparam int NV = 14;
    // vector: {kind[1:0], addr[7:0], data[7:0]}; kind 0 write, 1 host read, 2 lookup
    localparam logic [17:0] VEC [NV] = '{
        {2'd0, 8'h00, 8'h11}, {2'd0, 8'h01, 8'h22}, {2'd0, 8'hFF, 8'hA5},
        {2'd0, 8'h80, 8'h5A}, {2'd0, 8'h7F, 8'hC3}, {2'd2, 8'h01, 8'h22},
        {2'd2, 8'hFF, 8'hA5}, {2'd2, 8'h00, 8'h11}, {2'd2, 8'h80, 8'h5A},
        {2'd1, 8'h7F, 8'hC3}, {2'd1, 8'hFF, 8'hA5}, {2'd0, 8'h01, 8'h99},
        {2'd2, 8'h01, 8'h99}, {2'd1, 8'h00, 8'h11}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] lut_addr = '0;
    logic [DW-1:0] lut_data;
    logic          host_valid = 1'b0;
    logic          host_ready;
    logic          host_write = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          host_rvalid;
    logic [CW-1:0] refresh_interval = '0;

    int n_chk = 0;
    int n_fail = 0;
    int edges = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    tdm_lut #(.ADDR_W(AW), .DATA_W(DW), .RF_CNT_W(CW), .RF_MAX(4)) uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .lut_addr         (lut_addr),
        .lut_data         (lut_data),
        .host_valid       (host_valid),
        .host_ready       (host_ready),
        .host_write       (host_write),
        .host_addr        (host_addr),
        .host_wdata       (host_wdata),
        .host_rdata       (host_rdata),
        .host_rvalid      (host_rvalid),
        .refresh_interval (refresh_interval)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic to_host();
        @(negedge clk);
        while (edges % 2 == 0) @(negedge clk);
    endtask

    task automatic host_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        to_host();
        chk("R5 ready in idle host slot", int'(host_ready), 1);
        host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_valid = 1'b0; host_write = 1'b0;
    endtask

    task automatic host_rd(input logic [AW-1:0] a, input logic [DW-1:0] e);
        to_host();
        host_valid = 1'b1; host_write = 1'b0; host_addr = a;
        @(negedge clk);
        host_valid = 1'b0;
        chk("R5 host_rvalid", int'(host_rvalid), 1);
        chk("R5 host_rdata", int'(host_rdata), int'(e));
    endtask

    task automatic lookup(input logic [AW-1:0] a, input logic [DW-1:0] e);
        to_host();
        lut_addr = a;
        repeat (2) @(negedge clk);
        @(negedge clk);
        chk("R2 lookup result", int'(lut_data), int'(e));
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int blocked;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 / R1: reset state, lookup slot first
        chk("R9 lut_data after reset", int'(lut_data), 0);
        chk("R9 host_rvalid after reset", int'(host_rvalid), 0);
        host_valid = 1'b1; host_write = 1'b0;
        chk("R1 no ready in first (lookup) slot", int'(host_ready), 0);
        @(negedge clk);
        chk("R1 ready in following host slot", int'(host_ready), 1);
        host_valid = 1'b0;
        @(negedge clk);
        chk("R1 ready low again in lookup slot", int'(host_ready), 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            unique case (VEC[i][17:16])
                2'd0: host_wr(VEC[i][15:8], VEC[i][7:0]);
                2'd1: host_rd(VEC[i][15:8], VEC[i][7:0]);
                default: lookup(VEC[i][15:8], VEC[i][7:0]);
            endcase
        end

        // R2/R3: exact latency while host writes every host slot
        lookup(8'h80, 8'h5A);
        to_host();
        lut_addr = 8'hFF;
        host_valid = 1'b1; host_write = 1'b1; host_addr = 8'h20; host_wdata = 8'h01;
        @(negedge clk);
        chk("R3 held in lookup slot", int'(lut_data), 8'h5A);
        host_addr = 8'h21; host_wdata = 8'h02;
        @(negedge clk);
        chk("R2 old word one edge later", int'(lut_data), 8'h5A);
        host_addr = 8'h22;
        @(negedge clk);
        chk("R2 new word two edges later", int'(lut_data), 8'hA5);
        host_valid = 1'b0; host_write = 1'b0;

        // R4: write and lookup of the same address in the same slot
        lookup(8'h40, 8'hXX === 8'hXX ? 8'h00 : 8'h00);
        host_wr(8'h40, 8'h00);
        lookup(8'h40, 8'h00);
        to_host();
        host_valid = 1'b1; host_write = 1'b1; host_addr = 8'h40; host_wdata = 8'h6E;
        @(negedge clk);
        host_valid = 1'b0; host_write = 1'b0;
        chk("R4 old value kept", int'(lut_data), 8'h00);
        @(negedge clk);
        chk("R4 old value kept until update", int'(lut_data), 8'h00);
        @(negedge clk);
        chk("R4 written value visible", int'(lut_data), 8'h6E);

        // R6: interval 10 over 105 cycles gives 10 blocked host slots
        to_host();
        refresh_interval = 8'd10;
        blocked = 0;
        for (int c = 0; c < 105; c++) begin
            if (c > 0) @(negedge clk);
            if (edges % 2 == 1 && !host_ready) blocked++;
        end
        chk("R6 blocked host slots at interval 10", blocked, 10);
        refresh_interval = 8'd0;
        repeat (6) @(negedge clk);
        to_host();
        chk("R6 interval 0 raises nothing", int'(host_ready), 1);

        // R8 / R7: saturate, then stop; a held write waits for 4 slots
        refresh_interval = 8'd1;
        repeat (20) @(negedge clk);
        refresh_interval = 8'd0;
        host_valid = 1'b1; host_write = 1'b1; host_addr = 8'h10; host_wdata = 8'h77;
        blocked = 0;
        for (int c = 0; c < 30; c++) begin
            if (c > 0) @(negedge clk);
            if (edges % 2 == 1) begin
                if (host_ready) begin
                    @(negedge clk);
                    host_valid = 1'b0; host_write = 1'b0;
                    break;
                end
                blocked++;
            end
        end
        chk("R8 blocked host slots after saturation", blocked, 4);
        chk("R7 held write accepted after drain", int'(host_valid), 0);
        lookup(8'h10, 8'h77);
        host_rd(8'h10, 8'h77);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule